// File: doc/BRIEF.md
# String Load Execution Sequencer

This block carries out a string-load operation. It reads one element from memory at the address held in a source index, places it in the low part of an accumulator, and then moves the index up or down by the element size. A direction input sets which way the index moves. Elements can be 1, 2, 4 or 8 bytes wide. A repeat option re-issues loads, one element at a time, until a count register runs down to zero.

A start pulse captures the index, count, accumulator and operation settings. The block then asks for data through a request/ready read port until the sequence is complete. One cycle after the last element is written back, it raises a one-cycle done pulse and presents the updated register values. It never changes any status flags, so it has no flag ports. A fault on a memory response stops the sequence without changing any register for that element.

Top module: `strload_seq`

## Requirements
- R1: `op_size` selects the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, 3 is 64 bits. The loaded data replaces that many low bits of the accumulator. The accumulator bits above the element width keep their earlier value.
- R2: Each completed element changes the source index by exactly 1, 2, 4 or 8 bytes, matching `op_size`.
- R3: When `dir_down` is 0 the index is incremented, and when it is 1 the index is decremented.
- R4: The 64-bit element size is legal only when `addr_mode` is 2 or 3 (64-bit mode). An illegal start makes no memory access, leaves all registers unchanged, and ends with `done` and `fault` both high.
- R5: When `rep_en` is 1, the block loads `cnt_in` elements, and the count drops by one for each completed element. When `rep_en` is 0, exactly one element is loaded and the count is not changed.
- R6: A repeated operation that starts with a count of zero makes no memory access and finishes with all registers unchanged.
- R7: `addr_mode` 0 (16-bit mode) keeps the index modulo 2^16 and leaves bits 63:16 unchanged. `addr_mode` 1 (32-bit mode) keeps the index modulo 2^32 and leaves bits 63:32 unchanged. `mem_addr` is the index reduced to the mode width and zero-extended.
- R8: `done` is high for exactly one cycle. It rises in the cycle after the final handshake. `mem_req` is high only while `busy` is high.
- R9: A `start` received while `busy` is high is ignored.
- R10: A handshake with `mem_fault` high ends the sequence. The accumulator, index and count for that element stay unchanged, and `fault` is high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the block is idle |
| op_size | input | 2 | Element size code |
| addr_mode | input | 2 | 0: 16-bit, 1: 32-bit, 2/3: 64-bit |
| dir_down | input | 1 | 1 makes the index move downward |
| rep_en | input | 1 | Enables count-driven repeat |
| idx_in | input | 64 | Starting source index |
| cnt_in | input | CNT_W | Starting count |
| acc_in | input | 64 | Starting accumulator |
| mem_req | output | 1 | Read request |
| mem_addr | output | 64 | Read address |
| mem_ready | input | 1 | Response valid; handshake when high with mem_req |
| mem_rdata | input | 64 | Read data, element in the low bits |
| mem_fault | input | 1 | Response carries a fault |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | High with done when ended by a fault or an illegal start |
| idx_out | output | 64 | Current source index |
| cnt_out | output | CNT_W | Current count |
| acc_out | output | 64 | Current accumulator |

## Verification
The hardest case to reach is a fault in the middle of a repeated sequence. The register values must then show every element before the fault and nothing after it. The bench sets a faulting address that matches the second element of a three-element run. It also pulls `mem_ready` low for irregular stretches, so each handshake lands after a different number of wait cycles. A second start pulse, with very different inputs, is sent in the middle of a run to show that it has no effect on any later access or on the final values.

// File: rtl/strload_pkg.sv
package strload_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_WORD  = 2'd1,
        ESZ_DWORD = 2'd2,
        ESZ_QWORD = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_END  = 2'd2
    } seq_state_e;

    typedef struct packed {
        esz_e       size;
        logic [1:0] amode;
        logic       down;
        logic       rep;
    } op_cfg_t;

    function automatic logic is_legal(input esz_e size, input logic [1:0] amode);
        return !(size == ESZ_QWORD && !amode[1]);
    endfunction

    function automatic logic [XLEN-1:0] step_of(input esz_e size);
        return XLEN'(1) << size;
    endfunction

    function automatic logic [XLEN-1:0] next_index(input logic [XLEN-1:0] idx,
                                                   input op_cfg_t cfg);
        logic [XLEN-1:0] sum;
        sum = cfg.down ? (idx - step_of(cfg.size)) : (idx + step_of(cfg.size));
        case (cfg.amode)
            2'd0:    return {idx[XLEN-1:16], sum[15:0]};
            2'd1:    return {idx[XLEN-1:32], sum[31:0]};
            default: return sum;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] view_addr(input logic [XLEN-1:0] idx,
                                                  input logic [1:0] amode);
        case (amode)
            2'd0:    return {{(XLEN-16){1'b0}}, idx[15:0]};
            2'd1:    return {{(XLEN-32){1'b0}}, idx[31:0]};
            default: return idx;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] merge_acc(input logic [XLEN-1:0] acc,
                                                  input logic [XLEN-1:0] data,
                                                  input esz_e size);
        case (size)
            ESZ_BYTE:  return {acc[XLEN-1:8],  data[7:0]};
            ESZ_WORD:  return {acc[XLEN-1:16], data[15:0]};
            ESZ_DWORD: return {acc[XLEN-1:32], data[31:0]};
            default:   return data;
        endcase
    endfunction

endpackage

// File: rtl/strload_fsm.sv
module strload_fsm
    import strload_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic legal,
    input  logic zero_rep,
    input  logic last_elem,
    input  logic mem_ready,
    input  logic mem_fault,
    output logic capture,
    output logic commit,
    output logic mem_req,
    output logic busy,
    output logic done,
    output logic fault
);

    seq_state_e state_q, state_d;
    logic       fault_q, fault_d;

    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        capture = 1'b0;
        commit  = 1'b0;
        mem_req = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    capture = 1'b1;
                    fault_d = !legal;
                    if (!legal || zero_rep) state_d = ST_END;
                    else                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    if (mem_fault) begin
                        fault_d = 1'b1;
                        state_d = ST_END;
                    end else begin
                        commit = 1'b1;
                        if (last_elem) state_d = ST_END;
                    end
                end
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_END);
    assign fault = done && fault_q;

    // R8: completion pulse never lasts two cycles
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: requests only while an operation is active
    a_r8_req_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R10: a faulting response always leads straight to completion
    a_r10_fault_ends: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && mem_fault) |=> (done && fault));

endmodule

// File: rtl/strload_dp.sv
module strload_dp
    import strload_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             commit,
    input  op_cfg_t          cfg_in,
    input  logic [XLEN-1:0]  idx_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [XLEN-1:0]  acc_in,
    input  logic [XLEN-1:0]  rdata,
    output logic [XLEN-1:0]  addr,
    output logic             last_elem,
    output logic [XLEN-1:0]  idx_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [XLEN-1:0]  acc_q
);

    op_cfg_t     cfg_q;
    logic [15:0] stp16;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            idx_q <= '0;
            cnt_q <= '0;
            acc_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_in;
            idx_q <= idx_in;
            cnt_q <= cnt_in;
            acc_q <= acc_in;
        end else if (commit) begin
            idx_q <= next_index(idx_q, cfg_q);
            acc_q <= merge_acc(acc_q, rdata, cfg_q.size);
            if (cfg_q.rep) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign addr      = view_addr(idx_q, cfg_q.amode);
    assign last_elem = !cfg_q.rep || (cnt_q == CNT_W'(1));
    assign stp16     = 16'd1 << cfg_q.size;

    // R2 R3: low index bits move by the signed element size
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        commit |=> ((idx_q[15:0] - $past(idx_q[15:0])) ==
                    ($past(cfg_q.down) ? (16'd0 - stp16) : stp16)));

    // R5: count drops by one per repeated element
    a_r5_count: assert property (@(posedge clk) disable iff (rst)
        (commit && cfg_q.rep) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R7: 16-bit mode never disturbs upper index bits
    a_r7_upper16: assert property (@(posedge clk) disable iff (rst)
        (commit && cfg_q.amode == 2'd0) |=> (idx_q[XLEN-1:16] == $past(idx_q[XLEN-1:16])));

endmodule

// File: rtl/strload_seq.sv
module strload_seq
    import strload_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op_size,
    input  logic [1:0]       addr_mode,
    input  logic             dir_down,
    input  logic             rep_en,
    input  logic [63:0]      idx_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [63:0]      acc_in,
    output logic             mem_req,
    output logic [63:0]      mem_addr,
    input  logic             mem_ready,
    input  logic [63:0]      mem_rdata,
    input  logic             mem_fault,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [63:0]      idx_out,
    output logic [CNT_W-1:0] cnt_out,
    output logic [63:0]      acc_out
);

    op_cfg_t cfg_in;
    logic    capture, commit, last_elem, legal, zero_rep;

    assign cfg_in.size  = esz_e'(op_size);
    assign cfg_in.amode = addr_mode;
    assign cfg_in.down  = dir_down;
    assign cfg_in.rep   = rep_en;

    assign legal    = is_legal(cfg_in.size, addr_mode);
    assign zero_rep = rep_en && (cnt_in == '0);

    strload_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .legal     (legal),
        .zero_rep  (zero_rep),
        .last_elem (last_elem),
        .mem_ready (mem_ready),
        .mem_fault (mem_fault),
        .capture   (capture),
        .commit    (commit),
        .mem_req   (mem_req),
        .busy      (busy),
        .done      (done),
        .fault     (fault)
    );

    strload_dp #(.CNT_W(CNT_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .commit    (commit),
        .cfg_in    (cfg_in),
        .idx_in    (idx_in),
        .cnt_in    (cnt_in),
        .acc_in    (acc_in),
        .rdata     (mem_rdata),
        .addr      (mem_addr),
        .last_elem (last_elem),
        .idx_q     (idx_out),
        .cnt_q     (cnt_out),
        .acc_q     (acc_out)
    );

    // R9: while busy, registers move only on an accepted response
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !(mem_req && mem_ready)) |=>
        ($stable(idx_out) && $stable(acc_out) && $stable(cnt_out)));

    // R10: a faulting response leaves every register untouched
    a_r10_fault_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && mem_fault) |=>
        ($stable(idx_out) && $stable(acc_out) && $stable(cnt_out)));

endmodule

// File: tb/tb_strload_seq.sv
module tb_strload_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic [1:0]  addr_mode = 2'd0;
    logic        dir_down = 1'b0;
    logic        rep_en = 1'b0;
    logic [63:0] idx_in = '0;
    logic [63:0] cnt_in = '0;
    logic [63:0] acc_in = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;
    logic        busy, done, fault;
    logic [63:0] idx_out, cnt_out, acc_out;

    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    logic        finished = 1'b0;
    logic [7:0]  lfsr = 8'hB5;
    logic [63:0] exp_q[$];
    logic [63:0] fault_at = '0;
    logic        fault_on = 1'b0;

    always #10 clk = ~clk;

    strload_seq dut (
        .clk(clk), .rst(rst), .start(start), .op_size(op_size), .addr_mode(addr_mode),
        .dir_down(dir_down), .rep_en(rep_en), .idx_in(idx_in), .cnt_in(cnt_in),
        .acc_in(acc_in), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault), .busy(busy), .done(done),
        .fault(fault), .idx_out(idx_out), .cnt_out(cnt_out), .acc_out(acc_out)
    );

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A3C_96E1, ~a[31:0] + 32'h0001_3579};
    endfunction

    function automatic logic [63:0] trunc(input logic [63:0] v, input logic [1:0] m);
        if (m == 2'd0) return v & 64'h0000_0000_0000_FFFF;
        if (m == 2'd1) return v & 64'h0000_0000_FFFF_FFFF;
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // memory responder and per-access comparison against the expected address list
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = lfsr[0] | lfsr[3];
        mem_rdata = mem_word(mem_addr);
        mem_fault = fault_on && (mem_addr == fault_at);
        if (!rst) begin
            if (mem_req && !busy) check(1'b0, "R8 req outside busy", 64'(mem_req), 64'(0));
            if (mem_req && mem_ready && !mem_fault) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 R6 unexpected access", mem_addr, 64'(0));
                end else begin
                    check(mem_addr == exp_q[0], "R7 access address", mem_addr, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
        if (cyc > 150000) begin
            check(1'b0, "watchdog", 64'(cyc), 64'(0));
            finish_run();
        end
    end

    task automatic run_op(input string tag, input logic [1:0] sz, input logic [1:0] am,
                          input logic dn, input logic rp, input logic [63:0] idx,
                          input logic [63:0] cnt, input logic [63:0] acc,
                          input logic fon, input logic [63:0] fat, input int poke_at);
        logic [63:0] e_idx, e_acc, e_cnt, a, msk, stp, nxt;
        logic        e_fault;
        int          n, waited;
        e_idx = idx; e_acc = acc; e_cnt = cnt; e_fault = 1'b0;
        exp_q.delete();
        if (sz == 2'd3 && !am[1]) begin
            e_fault = 1'b1;
            n = 0;
        end else begin
            n = rp ? int'(cnt) : 1;
        end
        msk = (sz == 2'd3) ? ~64'd0 : ((64'd1 << (8 << sz)) - 64'd1);
        stp = 64'd1 << sz;
        for (int k = 0; k < n; k++) begin
            a = trunc(e_idx, am);
            if (fon && a == fat) begin
                e_fault = 1'b1;
                break;
            end
            exp_q.push_back(a);
            e_acc = (e_acc & ~msk) | (mem_word(a) & msk);
            nxt = dn ? e_idx - stp : e_idx + stp;
            if (am == 2'd0)      e_idx = {e_idx[63:16], nxt[15:0]};
            else if (am == 2'd1) e_idx = {e_idx[63:32], nxt[31:0]};
            else                 e_idx = nxt;
            if (rp) e_cnt = e_cnt - 64'd1;
        end
        fault_at = fat; fault_on = fon;
        op_size = sz; addr_mode = am; dir_down = dn; rep_en = rp;
        idx_in = idx; cnt_in = cnt; acc_in = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 3000) begin
            waited++;
            if (waited == poke_at) begin
                idx_in = 64'h5555_5555_5555_5555; acc_in = '0; cnt_in = 64'd9;
                op_size = 2'd1; dir_down = ~dn; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(done, {tag, " done seen"}, 64'(done), 64'(1));
        check(acc_out == e_acc, {tag, " accumulator"}, acc_out, e_acc);
        check(idx_out == e_idx, {tag, " index"}, idx_out, e_idx);
        check(cnt_out == e_cnt, {tag, " count"}, cnt_out, e_cnt);
        check(fault == e_fault, {tag, " fault flag"}, 64'(fault), 64'(e_fault));
        check(exp_q.size() == 0, {tag, " R5 all accesses made"}, 64'(exp_q.size()), 64'(0));
        @(negedge clk);
        check(!done && !busy, "R8 done single cycle", {62'd0, done, busy}, 64'(0));
        fault_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !mem_req, "R8 reset idle", {61'd0, busy, done, mem_req}, 64'(0));
        check(acc_out == 0 && idx_out == 0 && cnt_out == 0, "R1 reset registers", acc_out, 64'(0));
        // R1 R2 R3: single byte, upward, 32-bit mode
        run_op("R1 R2 R3 byte", 2'd0, 2'd1, 1'b0, 1'b0, 64'h0000_0000_0000_1000,
               64'd7, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'd0, 0);
        // R3 R5: words downward, repeat 3
        run_op("R3 R5 word", 2'd1, 2'd2, 1'b1, 1'b1, 64'h0000_0012_3456_7890,
               64'd3, 64'h1111_2222_3333_4444, 1'b0, 64'd0, 0);
        // R7: doublewords upward crossing 2^32 in 32-bit mode
        run_op("R7 dword wrap32", 2'd2, 2'd1, 1'b0, 1'b1, 64'hDEAD_0000_FFFF_FFF8,
               64'd4, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 64'd0, 0);
        // R7: bytes downward crossing zero in 16-bit mode
        run_op("R7 byte wrap16", 2'd0, 2'd0, 1'b1, 1'b1, 64'hABCD_0000_0000_0001,
               64'd3, 64'h0123_4567_89AB_CDEF, 1'b0, 64'd0, 0);
        // R2 R3: quadwords downward in 64-bit mode
        run_op("R2 R3 qword", 2'd3, 2'd3, 1'b1, 1'b1, 64'h8000_0000_0000_0010,
               64'd2, 64'h0, 1'b0, 64'd0, 0);
        // R4: quadword outside 64-bit mode is refused
        run_op("R4 illegal qword", 2'd3, 2'd1, 1'b0, 1'b1, 64'h0000_0000_0000_2000,
               64'd2, 64'h7777_7777_7777_7777, 1'b0, 64'd0, 0);
        // R6: zero count makes no access
        run_op("R6 zero count", 2'd2, 2'd2, 1'b0, 1'b1, 64'h0000_0000_0000_3000,
               64'd0, 64'h9999_8888_7777_6666, 1'b0, 64'd0, 0);
        // R10: fault on the second element of three
        run_op("R10 mid fault", 2'd1, 2'd2, 1'b0, 1'b1, 64'h0000_0000_0000_4000,
               64'd3, 64'h5A5A_5A5A_5A5A_5A5A, 1'b1, 64'h0000_0000_0000_4002, 0);
        // R9: second start during the run is ignored
        run_op("R9 start ignored", 2'd2, 2'd2, 1'b0, 1'b1, 64'h0000_0000_0000_5000,
               64'd5, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 64'd0, 3);
        // R1: non-repeat dword keeps upper half and count
        run_op("R1 R5 dword single", 2'd2, 2'd3, 1'b1, 1'b0, 64'h0000_0000_0000_6004,
               64'd11, 64'hCAFE_F00D_0000_0000, 1'b0, 64'd0, 0);
        finish_run();
    end

endmodule